// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides whether a conditional branch is taken and where it goes. Each cycle it receives a 4-bit condition selector, the four arithmetic flags (negative, zero, overflow, carry), the address of the instruction that follows the branch, and a signed 8-bit displacement. One clock edge later it presents a registered taken bit and the branch destination.

The selector covers several families of tests:

- an unconditional pair, always and never;
- single-flag tests on Z, C, V and N;
- a carry-based family for unsigned magnitude after a compare;
- an overflow-xor-sign family for two's-complement magnitude after a compare.

Selectors are arranged in pairs: the odd member of each pair is the logical inverse of the even member.

The destination is always computed, whether or not the branch is taken. It is the sign-extended displacement added to the already-advanced program counter, so a fetch unit can use it without waiting for the decision.

Top module: `brc_unit`

## Requirements
- R1: While `rst_n` is low, `taken_o` is 0 and `target_o` is 0 after the next rising clock edge.
- R2: Outputs are registered. Values driven on the inputs appear at `taken_o` and `target_o` after exactly one rising edge, and the outputs do not change between edges. `flags_i` bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R3: Selector 0x0 (always) gives taken = 1 for any flags. Selector 0x1 (never) gives taken = 0 for any flags.
- R4: Selector 0x7 (equal) gives taken = Z. Selector 0x6 (not equal) gives taken = !Z.
- R5: Selector 0x5 (carry set) gives taken = C and selector 0x4 (carry clear) gives taken = !C. Selector 0x9 (overflow set) gives taken = V and selector 0x8 (overflow clear) gives taken = !V.
- R6: Selector 0xB (minus) gives taken = N. Selector 0xA (plus) gives taken = !N.
- R7: Selector 0x2 (unsigned higher) gives taken when (C | Z) = 0. Selector 0x3 (unsigned lower-or-same) gives taken when (C | Z) = 1. Unsigned higher-or-same and lower use selectors 0x4 and 0x5 respectively.
- R8: Selector 0xC (signed greater-or-equal) gives taken when (N ^ V) = 0. Selector 0xD (signed less) gives taken when (N ^ V) = 1.
- R9: Selector 0xE (signed greater) gives taken when Z | (N ^ V) = 0. Selector 0xF (signed less-or-equal) gives taken when Z | (N ^ V) = 1.
- R10: `target_o` equals `next_pc_i` plus the sign-extended `disp_i`, for every selector and whether or not the branch is taken.
- R11: The destination addition wraps modulo 2^16 in both directions. For example, 0xFFF0 + 0x7F gives 0x006F, and 0x0005 + 0x80 gives 0xFF85.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 4 | Branch condition selector |
| flags_i | input | 4 | Flags {N, Z, V, C} |
| next_pc_i | input | 16 | Address of the instruction after the branch |
| disp_i | input | 8 | Signed displacement |
| taken_o | output | 1 | Registered branch decision |
| target_o | output | 16 | Registered branch destination |

## Verification
A fault in this block shows up one cycle after the inputs that trigger it, because the only state is the output register.

- A wrongly decoded selector or flag combination flips `taken_o` for just that pairing. The bench therefore sweeps every selector against all sixteen flag patterns.
- A sign-extension or carry fault in the adder corrupts `target_o` only for negative displacements or for sums that cross 0x0000/0xFFFF. The bench aims directed cases at those boundaries.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // Selector encoding: odd code is the inverse of the even code below it.
    typedef enum logic [3:0] {
        BR_ALWAYS = 4'h0,
        BR_NEVER  = 4'h1,
        BR_UHI    = 4'h2,
        BR_ULS    = 4'h3,
        BR_CCLR   = 4'h4,
        BR_CSET   = 4'h5,
        BR_NEQ    = 4'h6,
        BR_EQU    = 4'h7,
        BR_VCLR   = 4'h8,
        BR_VSET   = 4'h9,
        BR_POS    = 4'hA,
        BR_NEG    = 4'hB,
        BR_SGE    = 4'hC,
        BR_SLT    = 4'hD,
        BR_SGT    = 4'hE,
        BR_SLE    = 4'hF
    } br_cond_e;

    // Flag bit positions within the 4-bit flag vector.
    localparam int FLG_C = 0;
    localparam int FLG_V = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_N = 3;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       taken_o
);

    logic f_n, f_z, f_v, f_c;
    logic sgn_lt;
    logic base;

    assign f_n    = flags_i[FLG_N];
    assign f_z    = flags_i[FLG_Z];
    assign f_v    = flags_i[FLG_V];
    assign f_c    = flags_i[FLG_C];
    assign sgn_lt = f_n ^ f_v;

    // Evaluate the even member of each pair; bit 0 selects the inverse.
    always_comb begin
        unique case (cond_i[3:1])
            3'd0:    base = 1'b1;
            3'd1:    base = ~(f_c | f_z);
            3'd2:    base = ~f_c;
            3'd3:    base = ~f_z;
            3'd4:    base = ~f_v;
            3'd5:    base = ~f_n;
            3'd6:    base = ~sgn_lt;
            default: base = ~(f_z | sgn_lt);
        endcase
    end

    assign taken_o = base ^ cond_i[0];

endmodule

// File: rtl/brc_target_add.sv
module brc_target_add #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [PC_W-1:0]   target_o
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_noext
            assign disp_ext = disp_i[PC_W-1:0];
        end
    endgenerate

    // Sum truncated to PC_W bits: wraps around the address space.
    assign target_o = pc_i + disp_ext;

endmodule

// File: rtl/brc_unit.sv
module brc_unit #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        flags_i,
    input  logic [PC_W-1:0]   next_pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   target_o
);

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] target;
    } res_t;

    logic            taken_c;
    logic [PC_W-1:0] target_c;
    res_t            res_d, res_q;

    brc_cond_eval u_eval (
        .cond_i  (cond_i),
        .flags_i (flags_i),
        .taken_o (taken_c)
    );

    brc_target_add #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W)
    ) u_add (
        .pc_i     (next_pc_i),
        .disp_i   (disp_i),
        .target_o (target_c)
    );

    always_comb begin
        res_d        = res_q;
        res_d.taken  = taken_c;
        res_d.target = target_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign taken_o  = res_q.taken;
    assign target_o = res_q.target;

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cond_i,
    input logic [3:0]        flags_i,
    input logic [PC_W-1:0]   next_pc_i,
    input logic [DISP_W-1:0] disp_i,
    input logic              taken_o,
    input logic [PC_W-1:0]   target_o
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!taken_o && target_o == '0));

    p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'h0) |=> taken_o);

    p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'h1) |=> !taken_o);

    p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'h7) |=> (taken_o == $past(flags_i[2])));

    p_higher_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'h2 && flags_i[0]) |=> !taken_o);

    p_less_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'hD && (flags_i[3] ^ flags_i[1])) |=> taken_o);

    p_greater_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'hE && flags_i[2]) |=> !taken_o);

    p_zero_disp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_i == '0) |=> (target_o == $past(next_pc_i)));

endmodule

bind brc_unit brc_unit_chk #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .flags_i   (flags_i),
    .next_pc_i (next_pc_i),
    .disp_i    (disp_i),
    .taken_o   (taken_o),
    .target_o  (target_o)
);

// File: tb/tb_brc_unit.sv
module tb_brc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] next_pc_i = '0;
    logic [7:0]  disp_i = '0;
    logic        taken_o;
    logic [15:0] target_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        prev_taken = 1'b0;
    logic [15:0] prev_target = '0;

    always #10 clk = ~clk;

    brc_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .flags_i   (flags_i),
        .next_pc_i (next_pc_i),
        .disp_i    (disp_i),
        .taken_o   (taken_o),
        .target_o  (target_o)
    );

    // flags = {N,Z,V,C}
    function automatic logic exp_taken(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, cy;
        n = f[3]; z = f[2]; v = f[1]; cy = f[0];
        case (c)
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return (cy | z) == 1'b0;
            4'h3: return (cy | z) == 1'b1;
            4'h4: return !cy;
            4'h5: return cy;
            4'h6: return !z;
            4'h7: return z;
            4'h8: return !v;
            4'h9: return v;
            4'hA: return !n;
            4'hB: return n;
            4'hC: return (n ^ v) == 1'b0;
            4'hD: return (n ^ v) == 1'b1;
            4'hE: return (z | (n ^ v)) == 1'b0;
            default: return (z | (n ^ v)) == 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] exp_target(input logic [15:0] pc, input logic [7:0] d);
        int signed s;
        s = int'(pc) + int'($signed(d));
        return s[15:0];
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0, 4'h1:                return "R3";
            4'h6, 4'h7:                return "R4";
            4'h4, 4'h5, 4'h8, 4'h9:    return "R5";
            4'hA, 4'hB:                return "R6";
            4'h2, 4'h3:                return "R7";
            4'hC, 4'hD:                return "R8";
            default:                   return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] c, input logic [3:0] f,
                       input logic [15:0] pc, input logic [7:0] d, input string treq);
        logic        et;
        logic [15:0] eg;
        @(negedge clk);
        cond_i = c; flags_i = f; next_pc_i = pc; disp_i = d;
        #2;
        // R2: nothing changes before the clock edge
        check("R2", {31'd0, taken_o}, {31'd0, prev_taken});
        check("R2", {16'd0, target_o}, {16'd0, prev_target});
        et = exp_taken(c, f);
        eg = exp_target(pc, d);
        @(negedge clk);
        check(req_of(c), {31'd0, taken_o}, {31'd0, et});
        check(treq, {16'd0, target_o}, {16'd0, eg});
        prev_taken = et;
        prev_target = eg;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        cond_i = 4'h0; flags_i = 4'hF; next_pc_i = 16'h1234; disp_i = 8'h55;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, taken_o}, 32'd0);
        check("R1", {16'd0, target_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cond_i = 4'h1; flags_i = '0; next_pc_i = '0; disp_i = '0;
        @(negedge clk);
        prev_taken = 1'b0;
        prev_target = 16'h0000;

        // Sweep every selector against every flag pattern (R3..R9, R10)
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                run(4'(c), 4'(f), 16'(16'h4000 + c * 16 + f), 8'(f * 17 - 100), "R10");
            end
        end

        // R11: wrap-around corners
        run(4'h1, 4'h0, 16'hFFF0, 8'h7F, "R11");
        run(4'h0, 4'h0, 16'h0005, 8'h80, "R11");
        run(4'h7, 4'h0, 16'hFFFF, 8'h01, "R11");
        run(4'h6, 4'h4, 16'h0000, 8'hFF, "R11");
        run(4'h2, 4'h0, 16'h0080, 8'h80, "R11");

        // Constrained random mix (R10 target, decision per selector)
        for (int i = 0; i < 3000; i++) begin
            run(4'($urandom()), 4'($urandom()), 16'($urandom()), 8'($urandom()), "R10");
        end

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        cond_i = 4'h0; disp_i = 8'h10;
        @(negedge clk);
        check("R1", {31'd0, taken_o}, 32'd0);
        check("R1", {16'd0, target_o}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule